// File: doc/BRIEF.md
# Parallel Flash Identification Probe

This block finds out which byte-wide parallel NOR flash device sits on a bus. A one-cycle `start` pulse begins a probe. The block sends the unlock-and-identify command sequence through an internal command writer. It then reads the manufacturer byte and the device byte. When the device byte is the escape value, it reads two further device bytes. The assembled 32-bit code is compared against a table of supported codes, which is set by parameter.

If nothing matches on the first pass, the block returns the device to read mode and runs the whole probe again with a narrower command-address mask. Every probe ends by taking the device out of identification mode. The result is held on the outputs until the next start:

- a found flag,
- the matched table index,
- the raw identification word,
- the command-address mask in effect.

Top module: `flash_id_probe`

## Requirements
- R1: After reset, `busy`, `done` and `found` are 0, `addrMask` is 0x7FFF, and `flashCeN`, `flashOeN` and `flashWeN` are all 1.
- R2: A pass starts with three bus writes, in this order: 0xAA at 0x5555 AND mask, 0x55 at 0x2AAA AND mask, and 0x90 at 0x5555 AND mask. Every byte written by the block is one of 0xAA, 0x55, 0x90 or 0xF0.
- R3: The manufacturer byte is read at address 0 and goes to `idWord[7:0]`. The device byte is read at address 1 and goes to `idWord[15:8]`. Only addresses 0, 1, 0x0E and 0x0F are ever read.
- R4: When the device byte is 0x7E, bytes at 0x0E and 0x0F are read into `idWord[23:16]` and `idWord[31:24]`. Otherwise no further reads occur and the upper 16 bits are zero.
- R5: The first entry of the code table equal to the assembled word gives `found`=1 and its index on `chipIdx`. An entry whose code is zero ends the table, so entries after it never match.
- R6: The first pass uses mask 0x7FFF. If it finds no match, a second and final pass uses mask 0x07FF. `addrMask` shows the mask of the last pass.
- R7: Each probe ends with a reset command.
  - After a match whose entry has the single-write flag set, the reset is one write of 0xF0 at address 0.
  - Otherwise, including after a failed first pass, it is the three-write sequence ending in 0xF0 at 0x5555 AND mask.
- R8: `busy` rises in the cycle after `start` and stays high until `done`. `done` is a one-cycle pulse, after which `busy` is low.
- R9: `found`, `chipIdx` and `idWord` stay stable while idle. A failed probe reports `found`=0, `chipIdx`=0 and the last word read.
- R10: During every bus access `flashCeN` is low. During a read, `flashOeN` is low for WAIT_CYC+1 cycles and `flashWeN` stays high. `flashOeN` and `flashWeN` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a probe |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle pulse at probe completion |
| found | output | 1 | A supported code was matched |
| chipIdx | output | IDX_W | Index of the matched table entry |
| idWord | output | 32 | Assembled identification word |
| addrMask | output | 16 | Command-address mask of the last pass |
| flashAddr | output | ADDR_W | Flash address bus |
| flashDout | output | 8 | Data driven to the flash on writes |
| flashDin | input | 8 | Data returned by the flash on reads |
| flashCeN | output | 1 | Chip enable, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashWeN | output | 1 | Write enable, active low |

## Verification
The bound checker watches every cycle for the following:
- the strobe rules: chip enable during access, output and write enables never low together;
- writes carrying only command bytes and reads touching only the four identification addresses;
- a legal mask;
- the one-cycle `done` pulse and `busy` relation;
- results holding steady while idle.

Only the bench's flash model can show the rest:
- the exact order of unlock addresses under each mask;
- whether the narrow retry happens at all;
- escape-triggered extension;
- the table terminator hiding later entries;
- the choice between a one-write and a three-write reset.

These come out in the written addresses, the read and write counts, and the reported codes.

// File: rtl/fip_pkg.sv
package fip_pkg;
  localparam logic [7:0]  OP_UNLK_A   = 8'hAA;
  localparam logic [7:0]  OP_UNLK_B   = 8'h55;
  localparam logic [7:0]  OP_IDENT    = 8'h90;
  localparam logic [7:0]  OP_RESET    = 8'hF0;
  localparam logic [7:0]  ESC_BYTE    = 8'h7E;
  localparam logic [15:0] ADR_UNLK_A  = 16'h5555;
  localparam logic [15:0] ADR_UNLK_B  = 16'h2AAA;
  localparam logic [15:0] MASK_WIDE   = 16'h7FFF;
  localparam logic [15:0] MASK_NARROW = 16'h07FF;

  // strobes from control to datapath
  typedef struct packed {
    logic       startProbe;
    logic       goNarrow;
    logic       capByte;
    logic [1:0] bytePos;
    logic       latchHit;
    logic       latchMiss;
  } dpStrobe_t;
endpackage

// File: rtl/fip_bus.sv
module fip_bus #(
  parameter int ADDR_W   = 17,
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              ack,
  output logic [7:0]        rdData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDout,
  input  logic [7:0]        flashDin,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_CYC);

  logic             active;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      cnt       <= '0;
      ack       <= 1'b0;
      rdData    <= '0;
      flashAddr <= '0;
      flashDout <= '0;
      flashCeN  <= 1'b1;
      flashOeN  <= 1'b1;
      flashWeN  <= 1'b1;
    end else if (!active) begin
      ack <= 1'b0;
      if (req) begin
        active    <= 1'b1;
        cnt       <= '0;
        flashAddr <= reqAddr;
        flashDout <= reqData;
        flashCeN  <= 1'b0;
        flashOeN  <= isWrite;
        flashWeN  <= !isWrite;
      end
    end else if (cnt == LAST_CNT) begin
      active   <= 1'b0;
      ack      <= 1'b1;
      if (!flashOeN) rdData <= flashDin;
      flashCeN <= 1'b1;
      flashOeN <= 1'b1;
      flashWeN <= 1'b1;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fip_cmdseq.sv
module fip_cmdseq
  import fip_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic [7:0]        opcode,
  input  logic              single,
  input  logic [15:0]       mask,
  input  logic              busAck,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busData,
  output logic              cmdDone
);
  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT} cst_t;

  cst_t       state;
  logic [1:0] step;
  logic [7:0] opR;
  logic       singleR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= C_IDLE;
      step    <= 2'd0;
      opR     <= 8'h00;
      singleR <= 1'b0;
    end else begin
      case (state)
        C_IDLE: if (go) begin
          opR     <= opcode;
          singleR <= single;
          step    <= single ? 2'd2 : 2'd0;
          state   <= C_ISSUE;
        end
        C_ISSUE: state <= C_WAIT;
        C_WAIT: if (busAck) begin
          if (step == 2'd2) state <= C_IDLE;
          else begin
            step  <= step + 2'd1;
            state <= C_ISSUE;
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  always_comb begin
    busReq  = (state == C_ISSUE);
    cmdDone = (state == C_WAIT) && busAck && (step == 2'd2);
    case (step)
      2'd0:    begin busAddr = ADDR_W'(ADR_UNLK_A & mask); busData = OP_UNLK_A; end
      2'd1:    begin busAddr = ADDR_W'(ADR_UNLK_B & mask); busData = OP_UNLK_B; end
      default: begin
        busAddr = singleR ? '0 : ADDR_W'(ADR_UNLK_A & mask);
        busData = opR;
      end
    endcase
  end
endmodule

// File: rtl/fip_datapath.sv
module fip_datapath
  import fip_pkg::*;
#(
  parameter int                      NUM_CHIPS  = 6,
  parameter logic [NUM_CHIPS*32-1:0] CHIP_CODES = '0,
  parameter logic [NUM_CHIPS-1:0]    CHIP_SNGL  = '0,
  parameter int                      IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        dp,
  input  logic [7:0]       rdData,
  output logic             escSeen,
  output logic             hit,
  output logic             hitSingle,
  output logic             onWide,
  output logic [15:0]      addrMask,
  output logic             found,
  output logic [IDX_W-1:0] chipIdx,
  output logic [31:0]      idWord
);
  logic [31:0]      idWork;
  logic [IDX_W-1:0] matchIdx;

  // first matching entry before any zero terminator
  always_comb begin
    logic endSeen;
    endSeen   = 1'b0;
    hit       = 1'b0;
    hitSingle = 1'b0;
    matchIdx  = '0;
    for (int i = 0; i < NUM_CHIPS; i++) begin
      if (!endSeen && !hit) begin
        if (CHIP_CODES[i*32 +: 32] == 32'h0) endSeen = 1'b1;
        else if (CHIP_CODES[i*32 +: 32] == idWork) begin
          hit       = 1'b1;
          hitSingle = CHIP_SNGL[i];
          matchIdx  = IDX_W'(i);
        end
      end
    end
  end

  assign escSeen = (idWork[15:8] == ESC_BYTE);
  assign onWide  = (addrMask == MASK_WIDE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idWork   <= '0;
      addrMask <= MASK_WIDE;
      found    <= 1'b0;
      chipIdx  <= '0;
      idWord   <= '0;
    end else begin
      if (dp.startProbe) begin
        idWork   <= '0;
        addrMask <= MASK_WIDE;
        found    <= 1'b0;
        chipIdx  <= '0;
        idWord   <= '0;
      end
      if (dp.goNarrow) begin
        idWork   <= '0;
        addrMask <= MASK_NARROW;
      end
      if (dp.capByte) idWork[dp.bytePos*8 +: 8] <= rdData;
      if (dp.latchHit) begin
        found   <= 1'b1;
        chipIdx <= matchIdx;
        idWord  <= idWork;
      end
      if (dp.latchMiss) begin
        found   <= 1'b0;
        chipIdx <= '0;
        idWord  <= idWork;
      end
    end
  end
endmodule

// File: rtl/fip_ctrl.sv
module fip_ctrl
  import fip_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cmdDone,
  input  logic              busAck,
  input  logic              escSeen,
  input  logic              hit,
  input  logic              hitSingle,
  input  logic              onWide,
  output dpStrobe_t         dp,
  output logic              cmdGo,
  output logic [7:0]        cmdOp,
  output logic              cmdSingle,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              busy,
  output logic              done
);
  typedef enum logic [3:0] {
    S_IDLE, S_ID_GO, S_ID_WAIT, S_RD_REQ, S_RD_WAIT,
    S_RD_NEXT, S_CHECK, S_RST_WAIT, S_DONE
  } st_t;

  st_t        state, nxt;
  logic [2:0] rdStep;
  logic       retryPend;

  always_comb begin
    nxt       = state;
    dp        = '0;
    cmdGo     = 1'b0;
    cmdOp     = OP_IDENT;
    cmdSingle = 1'b0;
    rdReq     = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        dp.startProbe = 1'b1;
        nxt = S_ID_GO;
      end
      S_ID_GO: begin
        cmdGo = 1'b1;
        nxt   = S_ID_WAIT;
      end
      S_ID_WAIT: if (cmdDone) nxt = S_RD_REQ;
      S_RD_REQ: begin
        rdReq = 1'b1;
        nxt   = S_RD_WAIT;
      end
      S_RD_WAIT: if (busAck) begin
        dp.capByte = 1'b1;
        dp.bytePos = rdStep[1:0];
        nxt = S_RD_NEXT;
      end
      S_RD_NEXT:
        if ((rdStep == 3'd2 && !escSeen) || rdStep == 3'd4) nxt = S_CHECK;
        else nxt = S_RD_REQ;
      S_CHECK: begin
        cmdGo = 1'b1;
        cmdOp = OP_RESET;
        if (hit) begin
          dp.latchHit = 1'b1;
          cmdSingle   = hitSingle;
        end else if (!onWide) begin
          dp.latchMiss = 1'b1;
        end
        nxt = S_RST_WAIT;
      end
      S_RST_WAIT: if (cmdDone) begin
        if (retryPend) begin
          dp.goNarrow = 1'b1;
          nxt = S_ID_GO;
        end else nxt = S_DONE;
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    case (rdStep[1:0])
      2'd0:    rdAddr = ADDR_W'(0);
      2'd1:    rdAddr = ADDR_W'(1);
      2'd2:    rdAddr = ADDR_W'(14);
      default: rdAddr = ADDR_W'(15);
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      rdStep    <= 3'd0;
      retryPend <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_ID_GO) rdStep <= 3'd0;
      if (state == S_RD_WAIT && busAck) rdStep <= rdStep + 3'd1;
      if (state == S_CHECK) retryPend <= !hit && onWide;
    end
  end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import fip_pkg::*;
#(
  parameter int                      ADDR_W     = 17,
  parameter int                      WAIT_CYC   = 2,
  parameter int                      NUM_CHIPS  = 6,
  parameter logic [NUM_CHIPS*32-1:0] CHIP_CODES = {32'h00002420, 32'h00000000,
                                                   32'h01227E01, 32'h0000B5BF,
                                                   32'h00006B01, 32'h00005D1F},
  parameter logic [NUM_CHIPS-1:0]    CHIP_SNGL  = 6'b001010,
  localparam int                     IDX_W      = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [IDX_W-1:0]  chipIdx,
  output logic [31:0]       idWord,
  output logic [15:0]       addrMask,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDout,
  input  logic [7:0]        flashDin,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN
);
  dpStrobe_t         dp;
  logic              cmdGo, cmdSingle, cmdDone, cmdReq;
  logic [7:0]        cmdOp, cmdData, rdData;
  logic [ADDR_W-1:0] cmdAddr, rdAddr;
  logic              rdReq, busAck;
  logic              escSeen, hit, hitSingle, onWide;

  fip_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdDone(cmdDone), .busAck(busAck),
    .escSeen(escSeen), .hit(hit), .hitSingle(hitSingle), .onWide(onWide),
    .dp(dp), .cmdGo(cmdGo), .cmdOp(cmdOp), .cmdSingle(cmdSingle),
    .rdReq(rdReq), .rdAddr(rdAddr), .busy(busy), .done(done)
  );

  fip_datapath #(
    .NUM_CHIPS(NUM_CHIPS), .CHIP_CODES(CHIP_CODES),
    .CHIP_SNGL(CHIP_SNGL), .IDX_W(IDX_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .dp(dp), .rdData(rdData), .escSeen(escSeen),
    .hit(hit), .hitSingle(hitSingle), .onWide(onWide), .addrMask(addrMask),
    .found(found), .chipIdx(chipIdx), .idWord(idWord)
  );

  fip_cmdseq #(.ADDR_W(ADDR_W)) i_cmd (
    .clk(clk), .rstN(rstN), .go(cmdGo), .opcode(cmdOp), .single(cmdSingle),
    .mask(addrMask), .busAck(busAck), .busReq(cmdReq), .busAddr(cmdAddr),
    .busData(cmdData), .cmdDone(cmdDone)
  );

  fip_bus #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) i_bus (
    .clk(clk), .rstN(rstN), .req(cmdReq | rdReq), .isWrite(cmdReq),
    .reqAddr(cmdReq ? cmdAddr : rdAddr), .reqData(cmdData), .ack(busAck),
    .rdData(rdData), .flashAddr(flashAddr), .flashDout(flashDout),
    .flashDin(flashDin), .flashCeN(flashCeN), .flashOeN(flashOeN),
    .flashWeN(flashWeN)
  );
endmodule

// File: rtl/fip_probe_checker.sv
module fip_probe_checker #(
  parameter int ADDR_W = 17,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic [IDX_W-1:0]  chipIdx,
  input logic [31:0]       idWord,
  input logic [15:0]       addrMask,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [7:0]        flashDout,
  input logic              flashCeN,
  input logic              flashOeN,
  input logic              flashWeN
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashOeN && !flashWeN)); // R10
  AST_CE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (!flashOeN || !flashWeN) |-> !flashCeN); // R10
  AST_WRITE_CMD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> (flashDout == 8'hAA || flashDout == 8'h55 ||
                   flashDout == 8'h90 || flashDout == 8'hF0)); // R2
  AST_READ_ID_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> (flashAddr == ADDR_W'(0) || flashAddr == ADDR_W'(1) ||
                   flashAddr == ADDR_W'(14) || flashAddr == ADDR_W'(15))); // R3
  AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    addrMask == 16'h7FFF || addrMask == 16'h07FF); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R8
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(found) && $stable(chipIdx) && $stable(idWord))); // R9
  AST_FOUND_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    found |-> idWord != 32'h0); // R5
endmodule

bind flash_id_probe fip_probe_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_flash_id_probe.sv
module test_flash_id_probe;
  localparam int ADDR_W = 17;
  localparam int WAIT_CYC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, found, flashCeN, flashOeN, flashWeN;
  logic [2:0] chipIdx;
  logic [31:0] idWord;
  logic [15:0] addrMask;
  logic [ADDR_W-1:0] flashAddr;
  logic [7:0] flashDout, flashDin;

  always #5 clk = ~clk;

  flash_id_probe #(
    .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .NUM_CHIPS(6),
    .CHIP_CODES({32'h00002420, 32'h00000000, 32'h01227E01,
                 32'h0000B5BF, 32'h00006B01, 32'h00005D1F}),
    .CHIP_SNGL(6'b001010)
  ) i_flash_id_probe (.*);

  // flash model; mode 0: decodes 15 address bits, 1: needs exact 11-bit addresses, 2: decodes 11 bits
  logic [7:0] mMfr, mDev, mE2, mE3;
  logic [1:0] mMode;
  logic       idMode;
  int         unlk, wrCount, rdCount, oeRun, lastOeRun;
  logic [ADDR_W-1:0] addrLog [32];
  logic [7:0]        dataLog [32];

  always_comb begin
    if (idMode) begin
      case (flashAddr)
        17'd0:   flashDin = mMfr;
        17'd1:   flashDin = mDev;
        17'd14:  flashDin = mE2;
        17'd15:  flashDin = mE3;
        default: flashDin = 8'h00;
      endcase
    end else flashDin = 8'hFF;
  end

  function automatic bit addrOk(input logic [ADDR_W-1:0] a, input logic [15:0] full);
    case (mMode)
      2'd0:    return a[14:0] == full[14:0];
      2'd1:    return a == ADDR_W'(full & 16'h07FF);
      default: return a[10:0] == full[10:0];
    endcase
  endfunction

  always @(posedge flashWeN) begin
    if (wrCount < 32) begin
      addrLog[wrCount] = flashAddr;
      dataLog[wrCount] = flashDout;
    end
    wrCount++;
    if (flashDout == 8'hF0) begin
      idMode = 1'b0;
      unlk = 0;
    end else begin
      case (unlk)
        0: unlk = (addrOk(flashAddr, 16'h5555) && flashDout == 8'hAA) ? 1 : 0;
        1: unlk = (addrOk(flashAddr, 16'h2AAA) && flashDout == 8'h55) ? 2 : 0;
        default: begin
          if (addrOk(flashAddr, 16'h5555) && flashDout == 8'h90) idMode = 1'b1;
          unlk = 0;
        end
      endcase
    end
  end

  always @(negedge flashOeN) rdCount++;

  always @(posedge clk) begin
    if (flashOeN === 1'b0) oeRun++;
    else if (oeRun != 0) begin
      lastOeRun = oeRun;
      oeRun = 0;
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]  mfr, dev, e2, e3;
    logic [1:0]  mode;
    logic        expFound;
    logic [2:0]  expIdx;
    logic [31:0] expId;
    logic [15:0] expMask;
    logic [7:0]  expWr, expRd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h1F, 8'h5D, 8'h00, 8'h00, 2'd0, 1'b1, 3'd0, 32'h00005D1F, 16'h7FFF, 8'd6,  8'd2},
    '{8'h01, 8'h6B, 8'h00, 8'h00, 2'd0, 1'b1, 3'd1, 32'h00006B01, 16'h7FFF, 8'd4,  8'd2},
    '{8'hBF, 8'hB5, 8'h00, 8'h00, 2'd1, 1'b1, 3'd2, 32'h0000B5BF, 16'h07FF, 8'd12, 8'd4},
    '{8'h01, 8'h7E, 8'h22, 8'h01, 2'd0, 1'b1, 3'd3, 32'h01227E01, 16'h7FFF, 8'd4,  8'd4},
    '{8'h20, 8'h24, 8'h00, 8'h00, 2'd2, 1'b0, 3'd0, 32'h00002420, 16'h07FF, 8'd12, 8'd4},
    '{8'h01, 8'h7E, 8'h22, 8'h02, 2'd2, 1'b0, 3'd0, 32'h02227E01, 16'h07FF, 8'd12, 8'd8},
    '{8'h01, 8'h7E, 8'h22, 8'h01, 2'd1, 1'b1, 3'd3, 32'h01227E01, 16'h07FF, 8'd10, 8'd6},
    '{8'h01, 8'h6B, 8'h00, 8'h00, 2'd1, 1'b1, 3'd1, 32'h00006B01, 16'h07FF, 8'd10, 8'd4}
  };

  task automatic runProbe(input vec_t v);
    int cyc;
    bit busyOk;
    mMfr = v.mfr; mDev = v.dev; mE2 = v.e2; mE3 = v.e3; mMode = v.mode;
    idMode = 1'b0; unlk = 0; wrCount = 0; rdCount = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    busyOk = 1'b1;
    cyc = 0;
    while (done !== 1'b1 && cyc < 20000) begin
      if (busy !== 1'b1) busyOk = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk("R8 busy held until done", {31'd0, busyOk}, 32'd1);
    chk("R8 done reached", {31'd0, done}, 32'd1);
    chk("R5 found", {31'd0, found}, {31'd0, v.expFound});
    chk("R5 chipIdx", {29'd0, chipIdx}, {29'd0, v.expIdx});
    chk("R3 R4 idWord", idWord, v.expId);
    chk("R6 addrMask", {16'd0, addrMask}, {16'd0, v.expMask});
    chk("R7 write count", wrCount, {24'd0, v.expWr});
    chk("R4 read count", rdCount, {24'd0, v.expRd});
    chk("R7 identify mode left", {31'd0, idMode}, 32'd0);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
    chk("R8 busy low after done", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    idMode = 1'b0; unlk = 0; wrCount = 0; rdCount = 0; oeRun = 0; lastOeRun = 0;
    mMfr = 8'h00; mDev = 8'h00; mE2 = 8'h00; mE3 = 8'h00; mMode = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 found", {31'd0, found}, 32'd0);
    chk("R1 mask", {16'd0, addrMask}, 32'h7FFF);
    chk("R1 strobes", {29'd0, flashCeN, flashOeN, flashWeN}, 32'd7);

    for (int i = 0; i < NV; i++) begin
      runProbe(VEC[i]);
      if (i == 0) begin
        // R2 unlock order with wide mask
        chk("R2 write0", {7'd0, addrLog[0], dataLog[0]}, {7'd0, 17'h05555, 8'hAA});
        chk("R2 write1", {7'd0, addrLog[1], dataLog[1]}, {7'd0, 17'h02AAA, 8'h55});
        chk("R2 write2", {7'd0, addrLog[2], dataLog[2]}, {7'd0, 17'h05555, 8'h90});
        chk("R7 full reset last", {7'd0, addrLog[5], dataLog[5]}, {7'd0, 17'h05555, 8'hF0});
        chk("R10 read strobe width", lastOeRun, WAIT_CYC + 1);
      end
      if (i == 1) begin
        chk("R7 single reset", {7'd0, addrLog[3], dataLog[3]}, {7'd0, 17'h00000, 8'hF0});
      end
      if (i == 2) begin
        chk("R7 reset after failed pass", {7'd0, addrLog[5], dataLog[5]}, {7'd0, 17'h05555, 8'hF0});
        chk("R6 narrow unlock", {7'd0, addrLog[6], dataLog[6]}, {7'd0, 17'h00555, 8'hAA});
        chk("R6 narrow second", {7'd0, addrLog[7], dataLog[7]}, {7'd0, 17'h002AA, 8'h55});
        chk("R6 narrow identify", {7'd0, addrLog[8], dataLog[8]}, {7'd0, 17'h00555, 8'h90});
        chk("R7 narrow full reset", {7'd0, addrLog[11], dataLog[11]}, {7'd0, 17'h00555, 8'hF0});
      end
    end

    // R9 results held while idle
    begin
      logic f0;
      logic [2:0] x0;
      logic [31:0] w0;
      f0 = found; x0 = chipIdx; w0 = idWord;
      repeat (25) @(negedge clk);
      chk("R9 found held", {31'd0, found}, {31'd0, f0});
      chk("R9 idx held", {29'd0, chipIdx}, {29'd0, x0});
      chk("R9 id held", idWord, w0);
      chk("R9 no bus activity idle", {29'd0, flashCeN, flashOeN, flashWeN}, 32'd7);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule